// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a soft programmable logic array. It evaluates several two-level sum-of-products functions of a small input vector. An AND plane forms product terms from input literals. An OR plane merges the selected terms into each output. The path from `in_i` to `out_o` has no register. Product terms are shared, so a term is built once and can drive any number of outputs.

The personality is loaded one term per clock through a synchronous configuration port. Each write carries the term index, one 2-bit literal code per input, and an output connection mask. The same personality can be read back through a registered read port.

A mode input switches the OR plane to a restricted layout. In that layout each output can reach only its own fixed group of four terms, the way a fixed-OR array behaves.

Top module: `pla_core`

## Requirements
- R1: Literal code per input, where input i uses bits [2i+1:2i] of the term's literal field. 2'b01 needs the input to be 1. 2'b10 needs the input to be 0. 2'b00 leaves the input out of the term. 2'b11 forces the term to 0.
- R2: A product term is the AND of its participating literals. A term whose inputs are all coded 2'b00 evaluates to 1.
- R3: Output k is the OR of every product term whose mask bit k is set. An output with no connected term is 0.
- R4: One product term whose mask sets several bits drives all of those outputs at once.
- R5: With `pal_mode_i` = 0, any output may use any product term.
- R6: With `pal_mode_i` = 1, output k can use only terms 4k to 4k+3, taken modulo the term count. Mask bits that point outside that group have no effect on the output.
- R7: A write (`cfg_we_i` high at a rising edge) stores the literal field and mask for `cfg_idx_i`. The outputs reflect the new personality from the following cycle. Without a write, the personality does not change.
- R8: Reset (`rst_ni` low) clears every term's literal field and mask to zero. Until the first write after reset, all outputs are 0 and readback returns zero.
- R9: `rd_lit_o` and `rd_mask_o` return the stored literal field and mask of the term selected by `rd_idx_i` one cycle after it was presented. A write in the same cycle is not yet visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_mode_i | input | 1 | 1 restricts each output to its own term group |
| in_i | input | N_IN | Input vector of the logic functions |
| out_o | output | N_OUT | Combinational function outputs |
| cfg_we_i | input | 1 | Personality write strobe |
| cfg_idx_i | input | TW | Term index to write |
| cfg_lit_i | input | 2*N_IN | Literal codes of the term |
| cfg_mask_i | input | N_OUT | Output connection mask of the term |
| rd_idx_i | input | TW | Term index to read back |
| rd_lit_o | output | 2*N_IN | Read-back literal codes |
| rd_mask_o | output | N_OUT | Read-back output mask |

## Verification
The assertions check the following on every cycle:
- outputs and readback stay zero until the first write after reset;
- the outputs hold steady while inputs, mode and personality do not change;
- an output is never raised when the AND plane has no active term;
- a write is returned by a read of the same index in the cycle after it.

The exact sum-of-products value shows only in the bench scenarios, by comparison with a model. This covers each literal code, including the forcing code, the shared terms, and which mask bits are dropped in the restricted mode under the wrap-around group mapping.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10,
    LIT_KILL = 2'b11
  } lit_e;
endpackage

// File: rtl/pla_store.sv
module pla_store #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  localparam int LW = 2 * N_IN,
  localparam int TW = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [TW-1:0]           idx_i,
  input  logic [LW-1:0]           lit_i,
  input  logic [N_OUT-1:0]        mask_i,
  input  logic [TW-1:0]           rd_idx_i,
  output logic [LW-1:0]           rd_lit_o,
  output logic [N_OUT-1:0]        rd_mask_o,
  output logic [N_TERM*LW-1:0]    lit_all_o,
  output logic [N_TERM*N_OUT-1:0] mask_all_o
);
  logic [LW-1:0]    lit_q  [N_TERM];
  logic [N_OUT-1:0] mask_q [N_TERM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < N_TERM; t++) begin
        lit_q[t]  <= '0;
        mask_q[t] <= '0;
      end
    end else if (we_i && (32'(idx_i) < N_TERM)) begin
      lit_q[idx_i]  <= lit_i;
      mask_q[idx_i] <= mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lit_o  <= '0;
      rd_mask_o <= '0;
    end else if (32'(rd_idx_i) < N_TERM) begin
      rd_lit_o  <= lit_q[rd_idx_i];
      rd_mask_o <= mask_q[rd_idx_i];
    end else begin
      rd_lit_o  <= '0;
      rd_mask_o <= '0;
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_flat
    assign lit_all_o[t*LW +: LW]        = lit_q[t];
    assign mask_all_o[t*N_OUT +: N_OUT] = mask_q[t];
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  localparam int LW = 2 * N_IN
) (
  input  logic [N_IN-1:0]      in_i,
  input  logic [N_TERM*LW-1:0] lit_all_i,
  output logic [N_TERM-1:0]    term_o
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] ok;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      always_comb begin
        case (lit_e'(lit_all_i[t*LW + 2*i +: 2]))
          LIT_OFF: ok[i] = 1'b1;
          LIT_POS: ok[i] = in_i[i];
          LIT_NEG: ok[i] = ~in_i[i];
          default: ok[i] = 1'b0;
        endcase
      end
    end
    assign term_o[t] = &ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  parameter int GRP    = 4
) (
  input  logic                    pal_mode_i,
  input  logic [N_TERM-1:0]       term_i,
  input  logic [N_TERM*N_OUT-1:0] mask_all_i,
  output logic [N_OUT-1:0]        out_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = (GRP * k) % N_TERM;
    logic [N_TERM-1:0] conn;
    for (genvar t = 0; t < N_TERM; t++) begin : g_conn
      // distance from the group base, wrapping over the term count
      localparam int  OFS = (t + N_TERM - BASE) % N_TERM;
      localparam bit  OWN = (GRP >= N_TERM) || (OFS < GRP);
      if (OWN) begin : g_own
        assign conn[t] = mask_all_i[t*N_OUT + k];
      end else begin : g_far
        assign conn[t] = mask_all_i[t*N_OUT + k] & ~pal_mode_i;
      end
    end
    assign out_o[k] = |(conn & term_i);
  end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  parameter int GRP    = 4,
  localparam int LW = 2 * N_IN,
  localparam int TW = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pal_mode_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o,
  input  logic             cfg_we_i,
  input  logic [TW-1:0]    cfg_idx_i,
  input  logic [LW-1:0]    cfg_lit_i,
  input  logic [N_OUT-1:0] cfg_mask_i,
  input  logic [TW-1:0]    rd_idx_i,
  output logic [LW-1:0]    rd_lit_o,
  output logic [N_OUT-1:0] rd_mask_o
);
  logic [N_TERM*LW-1:0]    lit_all;
  logic [N_TERM*N_OUT-1:0] mask_all;
  logic [N_TERM-1:0]       term_w;

  pla_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) store_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .idx_i      (cfg_idx_i),
    .lit_i      (cfg_lit_i),
    .mask_i     (cfg_mask_i),
    .rd_idx_i   (rd_idx_i),
    .rd_lit_o   (rd_lit_o),
    .rd_mask_o  (rd_mask_o),
    .lit_all_o  (lit_all),
    .mask_all_o (mask_all)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) and_i (
    .in_i      (in_i),
    .lit_all_i (lit_all),
    .term_o    (term_w)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .GRP(GRP)) or_i (
    .pal_mode_i (pal_mode_i),
    .term_i     (term_w),
    .mask_all_i (mask_all),
    .out_o      (out_o)
  );
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  localparam int LW = 2 * N_IN,
  localparam int TW = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pal_mode_i,
  input logic [N_IN-1:0]  in_i,
  input logic [N_OUT-1:0] out_o,
  input logic             cfg_we_i,
  input logic [TW-1:0]    cfg_idx_i,
  input logic [LW-1:0]    cfg_lit_i,
  input logic [N_OUT-1:0] cfg_mask_i,
  input logic [TW-1:0]    rd_idx_i,
  input logic [LW-1:0]    rd_lit_o,
  input logic [N_OUT-1:0] rd_mask_o,
  input logic [N_TERM-1:0] term_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= 1'b0;
    else if (cfg_we_i) seen_q <= 1'b1;
  end

  // R8
  clear_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> out_o == '0);

  // R8
  clear_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |=> (rd_lit_o == '0 && rd_mask_o == '0));

  // R7
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && $stable(in_i) && $stable(pal_mode_i)) |-> $stable(out_o));

  // R3
  no_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i == '0 |-> out_o == '0);

  // R9
  rd_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_we_i && (32'(cfg_idx_i) < N_TERM)) ##1 (rd_idx_i == $past(cfg_idx_i)))
      |=> (rd_lit_o == $past(cfg_lit_i, 2) && rd_mask_o == $past(cfg_mask_i, 2)));
endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pal_mode_i (pal_mode_i),
  .in_i       (in_i),
  .out_o      (out_o),
  .cfg_we_i   (cfg_we_i),
  .cfg_idx_i  (cfg_idx_i),
  .cfg_lit_i  (cfg_lit_i),
  .cfg_mask_i (cfg_mask_i),
  .rd_idx_i   (rd_idx_i),
  .rd_lit_o   (rd_lit_o),
  .rd_mask_o  (rd_mask_o),
  .term_i     (term_w)
);

// File: tb/pla_core_tb_top.sv
`timescale 1ns/1ps
module pla_core_tb_top;
  localparam int NI = 4, NT = 8, NO = 4, G = 4;
  localparam int LW = 2 * NI, TW = 3;

  logic clk = 1'b0, rst_ni = 1'b0, pal = 1'b0, we = 1'b0;
  logic [NI-1:0] in_v = '0;
  logic [NO-1:0] out_v;
  logic [TW-1:0] idx = '0, ridx = '0;
  logic [LW-1:0] lit = '0, rlit;
  logic [NO-1:0] msk = '0, rmsk;

  int checks = 0, errors = 0;
  logic [LW-1:0] lit_m [NT];
  logic [NO-1:0] mask_m [NT];

  always #10 clk = ~clk;

  pla_core #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .GRP(G)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pal_mode_i(pal), .in_i(in_v), .out_o(out_v),
    .cfg_we_i(we), .cfg_idx_i(idx), .cfg_lit_i(lit), .cfg_mask_i(msk),
    .rd_idx_i(ridx), .rd_lit_o(rlit), .rd_mask_o(rmsk)
  );

  function automatic logic term_val(input logic [LW-1:0] l, input logic [NI-1:0] x);
    logic r = 1'b1;
    for (int i = 0; i < NI; i++) begin
      case (l[2*i +: 2])
        2'b01: if (!x[i]) r = 1'b0;
        2'b10: if (x[i])  r = 1'b0;
        2'b11: r = 1'b0;
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic owns(input int k, input int t);
    return ((((t - G * k) % NT) + NT) % NT) < G;
  endfunction

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x, input logic p);
    logic [NO-1:0] o = '0;
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < NO; k++)
        if (mask_m[t][k] && (!p || owns(k, t)) && term_val(lit_m[t], x)) o[k] = 1'b1;
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int t = 0; t < NT; t++) begin lit_m[t] = '0; mask_m[t] = '0; end
  endtask

  // one cycle: drive, check combinational output, then check readback
  task automatic step(input logic [NI-1:0] x, input logic p, input logic w,
                      input int ti, input logic [LW-1:0] l, input logic [NO-1:0] m,
                      input int ri, input string tag);
    logic [LW-1:0] el;
    logic [NO-1:0] em;
    @(negedge clk);
    in_v = x; pal = p; we = w; idx = TW'(ti); lit = l; msk = m; ridx = TW'(ri);
    el = lit_m[ri]; em = mask_m[ri];
    #5;
    chk(tag, 32'(out_v), 32'(model(x, p)));
    @(posedge clk); #1;
    if (w) begin lit_m[ti] = l; mask_m[ti] = m; end
    chk("R9 readback", {rlit, rmsk}, {el, em});
    we = 1'b0;
  endtask

  initial begin
    #(20.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_model();
    #35;
    in_v = 4'hF;
    #1;
    chk("R8 reset out", 32'(out_v), 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    for (int v = 0; v < 16; v++) step(4'(v), v[0], 1'b0, 0, '0, '0, v % NT, "R8 empty personality");

    // R2: all-off term on out0 is constant 1
    step(4'h0, 1'b0, 1'b1, 0, 8'h00, 4'b0001, 0, "R2 pre");
    step(4'h5, 1'b0, 1'b0, 0, '0, '0, 0, "R2 all-off term");
    // R1: true/complement literal mix on term1 to out1: in0=1, in1=0
    step(4'h0, 1'b0, 1'b1, 1, 8'b00_00_10_01, 4'b0010, 1, "R1 pre");
    step(4'h1, 1'b0, 1'b0, 0, '0, '0, 1, "R1 literal match");
    step(4'h3, 1'b0, 1'b0, 0, '0, '0, 1, "R1 literal miss");
    // R1: forcing code kills term
    step(4'h1, 1'b0, 1'b1, 1, 8'b11_00_10_01, 4'b0010, 1, "R1 pre kill");
    step(4'h1, 1'b0, 1'b0, 0, '0, '0, 1, "R1 forcing code");
    // R4: shared term feeding all outputs
    step(4'h0, 1'b0, 1'b1, 2, 8'b01_00_00_00, 4'b1111, 2, "R4 pre");
    step(4'h8, 1'b0, 1'b0, 0, '0, '0, 2, "R4 shared term");
    // R5/R6: term 5 on out0: used in PLA mode, dropped in PAL mode
    step(4'h0, 1'b0, 1'b1, 5, 8'h00, 4'b0101, 5, "R5 pre");
    step(4'h2, 1'b0, 1'b0, 0, '0, '0, 5, "R5 any term any output");
    step(4'h2, 1'b1, 1'b0, 0, '0, '0, 5, "R6 out-of-group ignored");
    // R6: wrap mapping, out2 owns terms 0-3
    step(4'h0, 1'b1, 1'b1, 3, 8'h00, 4'b0100, 3, "R6 pre wrap");
    step(4'h6, 1'b1, 1'b0, 0, '0, '0, 3, "R6 wrapped group");
    // R3: clear masks, output 0
    for (int t = 0; t < NT; t++) step(4'h0, 1'b0, 1'b1, t, 8'h00, 4'h0, t, "R3 clearing");
    step(4'hA, 1'b0, 1'b0, 0, '0, '0, 0, "R3 no connected term");

    // R7: random personality and inputs
    for (int n = 0; n < 600; n++) begin
      step(4'($urandom), 1'($urandom), ($urandom % 3) == 0, $urandom % NT,
           8'($urandom), 4'($urandom), $urandom % NT, "R7 random R5 R6");
    end

    // R8: mid-run reset clears everything
    @(negedge clk); rst_ni = 1'b0;
    #5; clear_model();
    chk("R8 mid reset out", 32'(out_v), 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    for (int t = 0; t < NT; t++) step(4'($urandom), 1'b0, 1'b0, 0, '0, '0, t, "R8 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule